// File: doc/BRIEF.md
# Serial Receiver with Per-Character Error Tags

This block turns an asynchronous serial line into a queue of received characters. It looks at the line once per pulse of an external sample enable, which runs at sixteen times the bit rate. The character length is 5, 6, 7 or 8 bits, and an optional even or odd parity bit may follow. Each completed character goes into a 64-entry queue. Every entry keeps three flags beside its data: parity error, framing error and break. When software pops an entry, the flags it reads belong to that same character.

The host reads the head of the queue through a combinational view and removes it with a one-cycle pop. Four outputs serve as interrupt conditions:
- a fill-level trigger with a selectable threshold;
- a sticky overrun flag;
- a line-status condition, raised by an overrun or by an error flag on the head entry;
- a character timeout for data that waits in the queue without activity.

A start edge that has gone high again by mid-bit is treated as noise and discarded.

Top module: `uart_rx_tagged`

## Requirements
- R1: A character starts with a low level at mid start bit. Data bits arrive LSB first, each sampled 16 ticks after the previous one. The length code cfg_len_i takes the values 0, 1, 2 and 3 for 5, 6, 7 and 8 bits. Stored data is right-aligned and its unused upper bits are zero.
- R2: With cfg_par_en_i set, a parity bit follows the data. cfg_par_odd_i=0 selects even parity and 1 selects odd. A mismatch sets the parity-error flag on that entry only.
- R3: If the line is high again when the start bit is sampled at mid-bit, the start is dropped and nothing is stored.
- R4: A low level sampled at the middle of the first stop bit sets the framing-error flag on that entry.
- R5: If the line stays low through start, data, parity and stop, exactly one entry is stored, with data 0x00 and only the break flag set. The next start is accepted only after the line has returned high.
- R6: The queue holds 64 entries and releases them in arrival order. The rd_* outputs show the head entry and pop_i removes it. A pop while the queue is empty has no effect.
- R7: A character that completes while the queue is full is discarded and sets overrun_o. overrun_o stays set until a cycle with ovr_clr_i high.
- R8: line_irq_o is high when overrun_o is set or when the head entry carries any error flag.
- R9: trig_o is high when level_o is at or above the threshold selected by cfg_trig_i. The codes 0, 1, 2 and 3 select 1, 16, 32 and 56 entries.
- R10: timeout_o rises when the queue has been non-empty, with no push and no pop, for 4 character times. One character time is 16 ticks × (start + data + parity + one stop bit). A push, a pop or an empty queue clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Sample enable at 16× bit rate |
| rxd_i | input | 1 | Serial line, idle high |
| cfg_len_i | input | 2 | Data length code |
| cfg_par_en_i | input | 1 | Parity bit present |
| cfg_par_odd_i | input | 1 | Odd parity when set |
| cfg_trig_i | input | 2 | Trigger threshold code |
| pop_i | input | 1 | Remove the head entry |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Head entry data |
| rd_perr_o | output | 1 | Head entry parity error |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_brk_o | output | 1 | Head entry break |
| empty_o | output | 1 | Queue empty |
| level_o | output | 7 | Entries held |
| trig_o | output | 1 | Level at or above threshold |
| overrun_o | output | 1 | Sticky overrun |
| line_irq_o | output | 1 | Line-status condition |
| timeout_o | output | 1 | Character timeout |

## Verification
The assertions assume three things about the inputs:
- tick_i pulses for one cycle at a time, at a rate well below the clock rate.
- Each bit on rxd_i stays steady for 16 ticks.
- The configuration does not change in the middle of a character.

The stimulus respects all three. It drives one tick every second clock and changes the line only at bit boundaries of 32 clocks. It writes the configuration only while the line is idle. Pops are single-cycle pulses issued between characters, so a pop never meets a push in the same cycle. The full-queue case still reaches the discard path through the overrun frame.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_HOLD
  } rx_state_e;

  function automatic int unsigned trig_thr(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 16;
      2'd2:    return 32;
      default: return 56;
    endcase
  endfunction

endpackage

// File: rtl/uart_rx_deser.sv
module uart_rx_deser
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rxd_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       push_o,
  output rx_entry_t  entry_o
);

  localparam int unsigned CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  logic [1:0]    sync_q;
  logic          rx;
  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    bit_q;
  logic [7:0]    sh_q;
  logic          pacc_q, pbit_q;
  logic          push_q;
  rx_entry_t     entry_q, entry_d;
  logic          last_bit, brk_det;

  assign rx = sync_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rxd_i};
  end

  assign last_bit = (bit_q == 3'(len_i) + 3'd4);
  // break needs every sampled bit low, stop bit included
  assign brk_det  = (sh_q == 8'h00) && !rx && !(par_en_i && pbit_q);

  always_comb begin
    entry_d      = '0;
    if (brk_det) begin
      entry_d.brk = 1'b1;
    end else begin
      entry_d.data = sh_q >> (2'd3 - len_i);
      entry_d.perr = par_en_i & (pacc_q ^ pbit_q ^ par_odd_i);
      entry_d.ferr = ~rx;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      pacc_q  <= 1'b0;
      pbit_q  <= 1'b0;
      push_q  <= 1'b0;
      entry_q <= '0;
    end else begin
      push_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (tick_i && !rx) begin
            state_q <= ST_START;
            cnt_q   <= '0;
            sh_q    <= '0;
            pacc_q  <= 1'b0;
            pbit_q  <= 1'b0;
          end
        end
        ST_START: begin
          if (tick_i) begin
            if (cnt_q == MID) begin
              if (rx) state_q <= ST_IDLE;
              else begin
                state_q <= ST_DATA;
                cnt_q   <= '0;
                bit_q   <= '0;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_DATA: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              sh_q   <= {rx, sh_q[7:1]};
              pacc_q <= pacc_q ^ rx;
              if (last_bit) state_q <= par_en_i ? ST_PAR : ST_STOP;
              else          bit_q   <= bit_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_PAR: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              pbit_q  <= rx;
              state_q <= ST_STOP;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (tick_i) begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              push_q  <= 1'b1;
              entry_q <= entry_d;
              state_q <= brk_det ? ST_HOLD : ST_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (rx) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign push_o  = push_q;
  assign entry_o = entry_q;

  // R1
  push_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o);

  // R5
  brk_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_o && entry_o.brk) |-> (entry_o.data == 8'h00 && !entry_o.perr && !entry_o.ferr));

endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 11,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  rdata_o,
  output logic [LW-1:0] level_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          drop_o
);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          wr, rd;

  assign empty_o = (lvl_q == '0);
  assign full_o  = (lvl_q == LW'(DEPTH));
  assign wr      = push_i & ~full_o;
  assign rd      = pop_i & ~empty_o;
  assign drop_o  = push_i & full_o;

  always_ff @(posedge clk_i) begin
    if (wr) mem_q[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (wr) wp_q <= wp_q + 1'b1;
      if (rd) rp_q <= rp_q + 1'b1;
      case ({wr, rd})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rp_q];
  assign level_o = lvl_q;

  // R6
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  // R7
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i) |=> (full_o && level_o == $past(level_o)));

  // R6
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i) |=> empty_o);

endmodule

// File: rtl/uart_rx_tmo.sv
module uart_rx_tmo #(
  parameter int unsigned OSR   = 16,
  parameter int unsigned CHARS = 4,
  localparam int unsigned LIM_MAX = CHARS * OSR * 12,
  localparam int unsigned TW      = $clog2(LIM_MAX + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       empty_i,
  input  logic       act_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  output logic       timeout_o
);

  logic [TW-1:0] cnt_q, lim;
  logic          to_q;

  // frame = start + (5..8) data + parity + one stop
  assign lim = TW'(CHARS * OSR * (7 + int'(len_i) + int'(par_en_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (empty_i || act_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (tick_i && !to_q) begin
      if (cnt_q >= lim - TW'(1)) to_q <= 1'b1;
      else                       cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = to_q;

  // R10
  to_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> !empty_i);

  // R10
  to_act_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> !timeout_o);

endmodule

// File: rtl/uart_rx_tagged.sv
module uart_rx_tagged
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR   = 16,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned CHARS = 4,
  localparam int unsigned LW   = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic [1:0]    cfg_len_i,
  input  logic          cfg_par_en_i,
  input  logic          cfg_par_odd_i,
  input  logic [1:0]    cfg_trig_i,
  input  logic          pop_i,
  input  logic          ovr_clr_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_perr_o,
  output logic          rd_ferr_o,
  output logic          rd_brk_o,
  output logic          empty_o,
  output logic [LW-1:0] level_o,
  output logic          trig_o,
  output logic          overrun_o,
  output logic          line_irq_o,
  output logic          timeout_o
);

  localparam int unsigned EW = $bits(rx_entry_t);

  logic      push, full, drop;
  rx_entry_t wentry, head;
  logic [EW-1:0] head_raw;
  logic      ovr_q;

  uart_rx_deser #(.OSR(OSR)) u_deser (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .rxd_i     (rxd_i),
    .len_i     (cfg_len_i),
    .par_en_i  (cfg_par_en_i),
    .par_odd_i (cfg_par_odd_i),
    .push_o    (push),
    .entry_o   (wentry)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .wdata_i (wentry),
    .pop_i   (pop_i),
    .rdata_o (head_raw),
    .level_o (level_o),
    .empty_o (empty_o),
    .full_o  (full),
    .drop_o  (drop)
  );

  uart_rx_tmo #(.OSR(OSR), .CHARS(CHARS)) u_tmo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .empty_i   (empty_o),
    .act_i     (push | pop_i),
    .len_i     (cfg_len_i),
    .par_en_i  (cfg_par_en_i),
    .timeout_o (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovr_q <= 1'b0;
    else if (drop)      ovr_q <= 1'b1;
    else if (ovr_clr_i) ovr_q <= 1'b0;
  end

  assign head       = rx_entry_t'(head_raw);
  assign rd_data_o  = head.data;
  assign rd_perr_o  = head.perr;
  assign rd_ferr_o  = head.ferr;
  assign rd_brk_o   = head.brk;
  assign overrun_o  = ovr_q;
  assign line_irq_o = ovr_q | (~empty_o & (head.perr | head.ferr | head.brk));
  assign trig_o     = (32'(level_o) >= trig_thr(cfg_trig_i));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o && !ovr_clr_i) |=> overrun_o);

  // R7
  ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full) |=> overrun_o);

  // R9
  trig_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> !empty_o);

endmodule

// File: tb/tb_uart_rx_tagged.sv
module tb_uart_rx_tagged;

  localparam int BITC = 32;

  logic       clk = 1'b0, rst_n = 1'b0, tick;
  logic       rxd = 1'b1;
  logic [1:0] cfg_len = 2'd3, cfg_trig = 2'd0;
  logic       cfg_pen = 1'b0, cfg_podd = 1'b0;
  logic       pop = 1'b0, ovr_clr = 1'b0;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk, empty, trig, overrun, line_irq, timeout;
  logic [6:0] level;

  int n_run = 0, n_fail = 0;
  int model[$];
  bit mon_en = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;

  uart_rx_tagged dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd),
    .cfg_len_i(cfg_len), .cfg_par_en_i(cfg_pen), .cfg_par_odd_i(cfg_podd),
    .cfg_trig_i(cfg_trig), .pop_i(pop), .ovr_clr_i(ovr_clr),
    .rd_data_o(rd_data), .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_brk_o(rd_brk),
    .empty_o(empty), .level_o(level), .trig_o(trig), .overrun_o(overrun),
    .line_irq_o(line_irq), .timeout_o(timeout)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int thr(input logic [1:0] c);
    return (c == 0) ? 1 : (c == 1) ? 16 : (c == 2) ? 32 : 56;
  endfunction

  function automatic int head_val();
    return {rd_brk, rd_ferr, rd_perr, rd_data};
  endfunction

  // per-clock comparison against the model while the line is quiet
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      check("R6 empty", int'(empty), int'(model.size() == 0));
      check("R9 trig", int'(trig), int'(model.size() >= thr(cfg_trig)));
    end
  end

  task automatic hold_bit(input logic v);
    rxd = v;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pen, input bit podd,
                      input bit flip, input bit stopv);
    bit p;
    int ent;
    mon_en = 1'b0;
    p = podd;
    hold_bit(1'b0);
    for (int i = 0; i < nb; i++) begin
      hold_bit(d[i]);
      p ^= d[i];
    end
    if (pen) hold_bit(p ^ flip);
    hold_bit(stopv);
    rxd = 1'b1;
    if (!stopv) repeat (BITC) @(negedge clk);
    ent = {1'b0, ~stopv, pen & flip, d & 8'((1 << nb) - 1)};
    if (model.size() < 64) model.push_back(ent);
    mon_en = 1'b1;
  endtask

  task automatic do_pop();
    pop = 1'b1;
    @(negedge clk);
    pop = 1'b0;
    if (model.size() > 0) void'(model.pop_front());
    @(negedge clk);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    check("R6 reset empty", int'(empty), 1);
    check("R6 reset level", int'(level), 0);
    check("R7 reset overrun", int'(overrun), 0);
    check("R8 reset line", int'(line_irq), 0);
    check("R10 reset timeout", int'(timeout), 0);
    mon_en = 1'b1;

    // R1 8-bit no parity
    send(8'hA5, 8, 0, 0, 0, 1);
    check("R1 8bit head", head_val(), model[0]);
    check("R9 trig at 1", int'(trig), 1);
    check("R8 clean head", int'(line_irq), 0);
    do_pop();
    check("R6 pop empties", int'(empty), 1);

    // R1 R2 5-bit even parity good, then bad
    mon_en = 1'b0;
    cfg_len = 2'd0; cfg_pen = 1'b1; cfg_podd = 1'b0;
    send(8'hF3, 5, 1, 0, 0, 1);
    check("R1 5bit data", int'(rd_data), 8'h13);
    check("R2 even ok", int'(rd_perr), 0);
    do_pop();
    send(8'h13, 5, 1, 0, 1, 1);
    check("R2 even bad", head_val(), model[0]);
    check("R8 perr line", int'(line_irq), 1);
    do_pop();

    // R2 7-bit odd parity good and bad
    mon_en = 1'b0;
    cfg_len = 2'd2; cfg_podd = 1'b1;
    send(8'h55, 7, 1, 1, 0, 1);
    send(8'h2A, 7, 1, 1, 1, 1);
    check("R2 odd ok", head_val(), model[0]);
    do_pop();
    check("R2 odd bad", head_val(), model[0]);
    do_pop();

    // R4 framing
    mon_en = 1'b0;
    cfg_len = 2'd1; cfg_pen = 1'b0; cfg_podd = 1'b0;
    send(8'h2C, 6, 0, 0, 0, 0);
    check("R4 ferr head", head_val(), model[0]);
    check("R8 ferr line", int'(line_irq), 1);
    do_pop();

    // R3 false start
    mon_en = 1'b0;
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (400) @(negedge clk);
    check("R3 no entry", int'(level), 0);
    mon_en = 1'b1;

    // R5 break
    mon_en = 1'b0;
    cfg_len = 2'd3;
    rxd = 1'b0;
    repeat (12 * BITC) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * BITC) @(negedge clk);
    model.push_back(32'h400);
    check("R5 single entry", int'(level), 1);
    check("R5 break head", head_val(), 32'h400);
    mon_en = 1'b1;
    do_pop();

    // R10 timeout: 8N1 -> 640 ticks = 1280 clocks
    send(8'h5A, 8, 0, 0, 0, 1);
    repeat (1150) @(negedge clk);
    check("R10 before limit", int'(timeout), 0);
    repeat (250) @(negedge clk);
    check("R10 after limit", int'(timeout), 1);
    do_pop();
    check("R10 cleared", int'(timeout), 0);

    // R6 R7 R9 fill
    for (int i = 0; i < 64; i++) begin
      send(8'((i * 37 + 5) & 8'hFF), 8, 0, 0, 0, 1);
      if (model.size() == 15 || model.size() == 16) begin
        cfg_trig = 2'd1; @(negedge clk);
        check("R9 thr16", int'(trig), int'(model.size() >= 16));
      end
      if (model.size() == 31 || model.size() == 32) begin
        cfg_trig = 2'd2; @(negedge clk);
        check("R9 thr32", int'(trig), int'(model.size() >= 32));
      end
      if (model.size() == 55 || model.size() == 56) begin
        cfg_trig = 2'd3; @(negedge clk);
        check("R9 thr56", int'(trig), int'(model.size() >= 56));
      end
    end
    check("R6 full level", int'(level), 64);
    check("R7 no overrun yet", int'(overrun), 0);
    send(8'hEE, 8, 0, 0, 0, 1);
    check("R7 overrun set", int'(overrun), 1);
    check("R7 level kept", int'(level), 64);
    check("R8 overrun line", int'(line_irq), 1);
    repeat (50) @(negedge clk);
    check("R7 sticky", int'(overrun), 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    check("R7 cleared", int'(overrun), 0);
    check("R8 after clear", int'(line_irq), 0);
    for (int i = 0; i < 64; i++) begin
      check("R6 order", head_val(), model[0]);
      do_pop();
    end
    check("R6 drained", int'(empty), 1);
    do_pop();
    check("R6 pop empty ignored", int'(level), 0);
    send(8'h3C, 8, 0, 0, 0, 1);
    check("R6 after empty pop", head_val(), 32'h03C);
    check("R6 level one", int'(level), 1);

    done = 1'b1;
    mon_en = 1'b0;
    summary();
  end

endmodule